// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address when the translation cache has no copy of the mapping. It takes a walk request over a valid/ready input channel. It checks the top index of the address against a table-length bound, then performs two dependent reads through a single-outstanding memory read port. The first read fetches the entry of the root table. The second read fetches the entry of the leaf table that the root entry names. It returns either the physical address or a fault code over a valid/ready output channel.

The virtual address splits into three fields: a 12-bit root index in bits 31:20, a 10-bit leaf index in bits 19:10, and a 10-bit byte offset within a 1 KiB page in bits 9:0. Table entries are 32 bits wide. Bits 31:10 carry a frame number and bit 0 marks the entry as mapped. The root table base and the length bound are plain inputs. The walker captures them, together with the address, in the cycle the request is accepted.

Back-pressure rules: `req_ready` is high only while the walker is idle. A result, once shown on `rsp_valid`, stays unchanged until `rsp_ready` takes it. A memory read request holds its address until `mem_req_ready` grants it. The memory answers each granted read with exactly one `mem_rsp_valid` pulse. No new read is issued before that answer arrives.

Top module: `pt_walker`

## Requirements
- R1: The address fields are offset = vaddr[9:0], leaf index = vaddr[19:10] and root index = vaddr[31:20].
- R2: If the root index is greater than or equal to the captured length bound, the result carries fault code 1 and physical address 0, and no memory read is issued.
- R3: The first read address is the captured base plus 4 times the root index, modulo 2^32.
- R4: If bit 0 of the root entry is 0, the result carries fault code 2 and physical address 0, after exactly one read.
- R5: The second read address is {root_entry[31:10], 10'b0} plus 4 times the leaf index, modulo 2^32.
- R6: If bit 0 of the leaf entry is 0, the result carries fault code 3 and physical address 0, after exactly two reads.
- R7: A successful walk returns fault code 0 and physical address {leaf_entry[31:10], offset}.
- R8: At most one memory read is outstanding. A read request that is not granted stays valid with the same address in the next cycle.
- R9: While rsp_valid is high and rsp_ready is low, the result stays valid and unchanged. No request is accepted while a result is pending.
- R10: The base, length bound and address are captured at acceptance. Changes to those inputs after acceptance do not affect the walk.
- R11: During reset, req_ready is 1 and rsp_valid and mem_req_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Physical byte address of the root table |
| tbl_limit | input | 13 | Number of root entries in use (0 to 4096) |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 length, 2 root entry unmapped, 3 leaf entry unmapped |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory grants the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry returned |

## Verification
Request acceptance and the length check happen in the same cycle. Both act on the live inputs, which the walker captures in that cycle. To exercise this, the bench replaces the base, the length bound and the address with different values in the very next cycle of every walk. It then judges the walk by the read addresses it observes and by the returned fault code, which must match values computed from the captured inputs. Length bounds of 0, 1, 4095 and 4096 are combined with root indexes just below, at and just above each bound. Random grant stalls, response latencies and result back-pressure cover the hold rules.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROOT_REQ,
    ST_ROOT_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_RESULT
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_ROOT  = 2'd2,
    FLT_LEAF  = 2'd3
  } walk_fault_e;

endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int OUTER_W = 12
) (
  input  logic [VA_W-1:0]                 vaddr,
  input  logic [OUTER_W:0]                limit,
  output logic [OUTER_W-1:0]              root_idx,
  output logic [VA_W-OFF_W-OUTER_W-1:0]   leaf_idx,
  output logic [OFF_W-1:0]                offset,
  output logic                            in_range
);
  localparam int INNER_W = VA_W - OFF_W - OUTER_W;

  assign offset   = vaddr[OFF_W-1:0];
  assign leaf_idx = vaddr[OFF_W +: INNER_W];
  assign root_idx = vaddr[VA_W-1 -: OUTER_W];
  assign in_range = ({1'b0, root_idx} < limit);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 10
) (
  input  logic [PA_W-1:0]       pte,
  output logic                  mapped,
  output logic [PA_W-OFF_W-1:0] frame
);
  logic unused_pte_bits;

  assign mapped          = pte[0];
  assign frame           = pte[PA_W-1:OFF_W];
  assign unused_pte_bits = ^pte[OFF_W-1:1];
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        in_range,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_mapped,
  input  logic        rsp_ready,
  output walk_state_e state,
  output logic        req_ready,
  output logic        mem_req_valid,
  output logic        rsp_valid,
  output logic        cap_req,
  output logic        cap_root,
  output logic        cap_leaf,
  output walk_fault_e fault
);
  walk_state_e state_q, state_d;
  walk_fault_e fault_q, fault_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  always_comb begin
    state_d       = state_q;
    fault_d       = fault_q;
    req_ready     = 1'b0;
    mem_req_valid = 1'b0;
    rsp_valid     = 1'b0;
    cap_req       = 1'b0;
    cap_root      = 1'b0;
    cap_leaf      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          cap_req = 1'b1;
          if (in_range) begin
            fault_d = FLT_NONE;
            state_d = ST_ROOT_REQ;
          end else begin
            fault_d = FLT_LIMIT;
            state_d = ST_RESULT;
          end
        end
      end
      ST_ROOT_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_ROOT_WAIT;
      end
      ST_ROOT_WAIT: begin
        if (mem_rsp_valid) begin
          if (pte_mapped) begin
            cap_root = 1'b1;
            state_d  = ST_LEAF_REQ;
          end else begin
            fault_d = FLT_ROOT;
            state_d = ST_RESULT;
          end
        end
      end
      ST_LEAF_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) state_d = ST_LEAF_WAIT;
      end
      ST_LEAF_WAIT: begin
        if (mem_rsp_valid) begin
          if (pte_mapped) begin
            cap_leaf = 1'b1;
            fault_d  = FLT_NONE;
          end else begin
            fault_d = FLT_LEAF;
          end
          state_d = ST_RESULT;
        end
      end
      ST_RESULT: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state = state_q;
  assign fault = fault_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int OUTER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PA_W-1:0]    tbl_base,
  input  logic [OUTER_W:0]   tbl_limit,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PA_W-1:0]    mem_rsp_data
);
  localparam int INNER_W = VA_W - OFF_W - OUTER_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int PTE_SH  = 2;
  localparam int ROOT_PAD = PA_W - OUTER_W - PTE_SH;
  localparam int LEAF_PAD = PA_W - INNER_W - PTE_SH;

  walk_state_e state;
  walk_fault_e fault;
  logic cap_req, cap_root, cap_leaf;
  logic in_range, pte_mapped;

  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    base_q;
  logic [FRAME_W-1:0] leaf_tbl_q;
  logic [PA_W-1:0]    paddr_q;

  logic [OUTER_W-1:0] live_root_idx;
  logic [INNER_W-1:0] live_leaf_idx;
  logic [OFF_W-1:0]   live_offset;
  logic [OUTER_W-1:0] root_idx;
  logic [INNER_W-1:0] leaf_idx;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] pte_frame;

  // Range check acts on the live request so a bad index never reaches memory.
  ptw_index_split #(.VA_W(VA_W), .OFF_W(OFF_W), .OUTER_W(OUTER_W)) u_live_split (
    .vaddr    (req_vaddr),
    .limit    (tbl_limit),
    .root_idx (live_root_idx),
    .leaf_idx (live_leaf_idx),
    .offset   (live_offset),
    .in_range (in_range)
  );

  logic unused_live;
  logic unused_range;
  assign unused_live = ^{live_root_idx, live_leaf_idx, live_offset};

  ptw_index_split #(.VA_W(VA_W), .OFF_W(OFF_W), .OUTER_W(OUTER_W)) u_held_split (
    .vaddr    (va_q),
    .limit    ({(OUTER_W+1){1'b1}}),
    .root_idx (root_idx),
    .leaf_idx (leaf_idx),
    .offset   (offset),
    .in_range (unused_range)
  );

  ptw_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W)) u_decode (
    .pte    (mem_rsp_data),
    .mapped (pte_mapped),
    .frame  (pte_frame)
  );

  ptw_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .in_range      (in_range),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_mapped    (pte_mapped),
    .rsp_ready     (rsp_ready),
    .state         (state),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .rsp_valid     (rsp_valid),
    .cap_req       (cap_req),
    .cap_root      (cap_root),
    .cap_leaf      (cap_leaf),
    .fault         (fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q       <= '0;
      base_q     <= '0;
      leaf_tbl_q <= '0;
      paddr_q    <= '0;
    end else begin
      if (cap_req) begin
        va_q    <= req_vaddr;
        base_q  <= tbl_base;
        paddr_q <= '0;
      end
      if (cap_root) leaf_tbl_q <= pte_frame;
      if (cap_leaf) paddr_q    <= {pte_frame, offset};
    end
  end

  logic [PA_W-1:0] root_addr, leaf_addr;
  assign root_addr = base_q + {{ROOT_PAD{1'b0}}, root_idx, {PTE_SH{1'b0}}};
  assign leaf_addr = {leaf_tbl_q, {OFF_W{1'b0}}} + {{LEAF_PAD{1'b0}}, leaf_idx, {PTE_SH{1'b0}}};

  assign mem_req_addr = (state == ST_LEAF_REQ) ? leaf_addr : root_addr;
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid
);
  logic [1:0] rd_cnt;
  logic [1:0] out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (req_valid && req_ready) rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 2'd1;
      if (mem_req_valid && mem_req_ready) out_cnt <= out_cnt + 2'd1;
      else if (mem_rsp_valid && out_cnt != 2'd0) out_cnt <= out_cnt - 2'd1;
    end
  end

  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_n |-> (req_ready && !rsp_valid && !mem_req_valid));

  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt != 2'd0) |-> !mem_req_valid);

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_no_accept_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_limit_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd1) |-> (rd_cnt == 2'd0 && rsp_paddr == '0));

  assert_root_fault_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd2) |-> (rd_cnt == 2'd1 && rsp_paddr == '0));

  assert_leaf_fault_two_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd3) |-> (rd_cnt == 2'd2 && rsp_paddr == '0));

  assert_success_two_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rd_cnt == 2'd2));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_pt_walker_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] tbl_base = '0;
  logic [12:0] tbl_limit = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int failures = 0;
  int nreads = 0;
  logic [31:0] obs_addr [0:1];
  int inv_mode = 0;   // 0 hashed, 1 root unmapped, 2 leaf unmapped, 3 all mapped
  bit mem_stall = 1'b0;
  bit rsp_stall = 1'b0;

  // Table contents: arithmetic function of the entry address and read number.
  function automatic logic [31:0] table_word(input logic [31:0] a, input int idx);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    table_word = {h[31:10], 9'd0, (h[4:2] != 3'd0)};
    if ((inv_mode == 1 && idx == 0) || (inv_mode == 2 && idx == 1)) table_word[0] = 1'b0;
    if (inv_mode == 3) table_word[0] = 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Memory model: grants on a negedge decision, answers after 0..2 idle cycles.
  initial begin : mem_model
    bit          pend;
    int          pdelay;
    int          pidx;
    logic [31:0] pa;
    pend = 1'b0; pdelay = 0; pidx = 0; pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pdelay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = table_word(pa, pidx);
          pend = 1'b0;
        end else begin
          pdelay--;
        end
      end
      mem_req_ready = mem_stall ? (($urandom % 3) != 0) : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (nreads < 2) obs_addr[nreads] = mem_req_addr;
        pidx   = nreads;
        pa     = mem_req_addr;
        nreads++;
        pend   = 1'b1;
        pdelay = mem_stall ? int'($urandom % 3) : 0;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [12:0] lim);
    logic [11:0] ri;
    logic [9:0]  li;
    logic [9:0]  off;
    logic [31:0] a0, a1, p0, p1, exp_pa;
    int          exp_f, exp_n;
    logic [31:0] got_pa;
    logic [1:0]  got_f;
    ri = va[31:20]; li = va[19:10]; off = va[9:0];
    a0 = '0; a1 = '0; exp_pa = '0;
    if ({1'b0, ri} >= lim) begin
      exp_f = 1; exp_n = 0;
    end else begin
      a0 = base + {18'd0, ri, 2'b00};
      p0 = table_word(a0, 0);
      if (!p0[0]) begin
        exp_f = 2; exp_n = 1;
      end else begin
        a1 = {p0[31:10], 10'd0} + {20'd0, li, 2'b00};
        p1 = table_word(a1, 1);
        if (!p1[0]) begin
          exp_f = 3; exp_n = 2;
        end else begin
          exp_f = 0; exp_n = 2; exp_pa = {p1[31:10], off};
        end
      end
    end
    @(negedge clk);
    nreads = 0;
    req_vaddr = va; tbl_base = base; tbl_limit = lim; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R10: disturb every captured input right after acceptance.
    req_vaddr = ~va; tbl_base = base ^ 32'h5A5A_0F0F; tbl_limit = '0;
    forever begin
      rsp_ready = rsp_stall ? (($urandom % 2) == 1) : 1'b1;
      if (rsp_valid && rsp_ready) break;
      @(negedge clk);
    end
    got_pa = rsp_paddr; got_f = rsp_fault;
    @(negedge clk);
    rsp_ready = 1'b0;
    case (exp_f)
      1: check(got_f == 2'd1, "R2 limit fault code", {30'd0, got_f}, 32'd1);
      2: check(got_f == 2'd2, "R4 root fault code", {30'd0, got_f}, 32'd2);
      3: check(got_f == 2'd3, "R6 leaf fault code", {30'd0, got_f}, 32'd3);
      default: check(got_f == 2'd0, "R7 success code", {30'd0, got_f}, 32'd0);
    endcase
    check(got_pa == exp_pa, "R7 paddr (R1 offset field)", got_pa, exp_pa);
    check(nreads == exp_n, "R2 R4 R6 read count", nreads, exp_n);
    if (exp_n >= 1 && nreads >= 1)
      check(obs_addr[0] == a0, "R3 root read addr (R10 captured base)", obs_addr[0], a0);
    if (exp_n == 2 && nreads == 2)
      check(obs_addr[1] == a1, "R5 leaf read addr (R1 leaf field)", obs_addr[1], a1);
    check(!rsp_valid && req_ready, "R9 back to idle", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin : stim
    logic [12:0] lims [0:5];
    lims[0] = 13'd0; lims[1] = 13'd1; lims[2] = 13'd2;
    lims[3] = 13'd777; lims[4] = 13'd4095; lims[5] = 13'd4096;
    #1;
    check(req_ready && !rsp_valid && !mem_req_valid, "R11 reset state",
          {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Length bound sweep around each boundary.
    inv_mode = 3;
    for (int l = 0; l < 6; l++) begin
      for (int d = -1; d <= 1; d++) begin
        int r;
        r = int'(lims[l]) + d;
        if (r >= 0 && r <= 4095)
          walk({r[11:0], 10'h155, 10'h2AA}, 32'h0001_0000 + 32'(l * 64), lims[l]);
      end
      walk({12'hFFF, 10'h3FF, 10'h3FF}, 32'h0000_4000, lims[l]);
      walk({12'h000, 10'h000, 10'h000}, 32'h0000_4000, lims[l]);
    end
    // Forced faults at each level.
    inv_mode = 1;
    walk(32'h1234_5678, 32'h0002_0000, 13'd4096);
    walk(32'h0000_0001, 32'hFFFF_FFF0, 13'd4096);
    inv_mode = 2;
    walk(32'h1234_5678, 32'h0002_0000, 13'd4096);
    walk(32'hFFF0_0000, 32'h0000_0000, 13'd4096);
    // Base wrap-around and leaf-index extremes.
    inv_mode = 3;
    walk({12'd7, 10'h3FF, 10'h001}, 32'hFFFF_FFF0, 13'd4096);
    walk({12'd0, 10'h000, 10'h3FF}, 32'hFFFF_FFFC, 13'd1);
    // Random walks with memory and result back-pressure.
    mem_stall = 1'b1;
    rsp_stall = 1'b1;
    for (int n = 0; n < 300; n++) begin
      inv_mode = int'($urandom % 4);
      walk($urandom, $urandom & 32'hFFFF_FFFC, 13'($urandom % 4097));
    end
    report();
    $finish;
  end
endmodule